// File: doc/BRIEF.md
# Clock Control and Status Register

This block is the main control/status word of a microcontroller clock controller. Software uses it to switch the internal and external oscillators on and off, to bypass the external oscillator, to arm the clock-security detector, to switch the PLL on and off, and to adjust the trim of the internal oscillator. Hardware uses the same word to show whether each oscillator is ready, whether the PLL is locked, and the factory calibration of the internal oscillator. A second small register holds the select code for the clock-output pin multiplexer.

Writes arrive on a simple one-cycle bus with one strobe per byte lane. A one-bit register index selects the target: 0 is the control word and 1 is the clock-output select. Reads are combinational and have no wait state. Hardware can override software. Entry into a low-power mode switches the PLL off. While the system clock runs from the PLL, or is about to switch to it, the PLL cannot be switched off by software.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset, the control word reads 0x0000_0083 when the calibration input is 0 and the internal ready input is high. Internal enable is 1, trim is 5'b10000, and all other enables, the clock-output enable and the select register are 0.
- R2: Only these control-word bits are writable: bit 0 (internal enable) and bits 7:3 (trim) in lane 0; bit 16 (external enable), bit 18 (bypass) and bit 19 (security enable) in lane 2; bit 24 (PLL enable) in lane 3. A bit changes only when its lane strobe is set, and the new value drives its output from the next cycle.
- R3: Bits 2, 23:20 and 31:26 read as zero. Writes to these bits, to the ready bits (1, 17, 25), to the calibration byte (15:8) and to lane 1 have no effect.
- R4: Bit 25 (PLL ready) shows the PLL lock input delayed by one clock.
- R5: Bit 1 (internal ready) and bit 17 (external ready) show their raw ready inputs after two clocks of synchronisation.
- R6: A stop-entry or standby-entry pulse clears the PLL enable on the next edge. This has priority over a write of 1 in the same cycle and over the protection in R7.
- R7: A software write of 0 to the PLL enable is ignored while the current or the requested system-clock source is the PLL (source code 2'b10). With any other source code, the write clears the enable.
- R8: The security detector output is high only while bit 19 is set and the synchronised external ready flag is set.
- R9: Bits 15:8 show the calibration input directly, in the same cycle.
- R10: Register index 1 holds a 3-bit output select in bits 2:0, written through lane 0. Bit 2 enables the clock output. Bits 1:0 pick the source: 0 system clock, 1 internal oscillator, 2 external oscillator, 3 PLL divided by 2. Bits 31:3 read as zero. Writes to either register leave the other unchanged.
- R11: Read data depends only on the read index and the current state. It changes in the same cycle as the read index, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 1 | Write target: 0 control word, 1 output select |
| wr_strb | input | 4 | Byte-lane write strobes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 control word, 1 output select |
| rd_data | output | 32 | Combinational read data |
| int_osc_rdy_raw | input | 1 | Internal oscillator ready, unsynchronised |
| ext_osc_rdy_raw | input | 1 | External oscillator ready, unsynchronised |
| pll_lock | input | 1 | PLL lock indication |
| int_osc_cal | input | 8 | Factory calibration of the internal oscillator |
| stop_enter | input | 1 | Pulse on entry to stop mode |
| standby_enter | input | 1 | Pulse on entry to standby mode |
| sysclk_cur | input | 2 | Current system-clock source code |
| sysclk_next | input | 2 | Requested system-clock source code |
| int_osc_en | output | 1 | Internal oscillator enable |
| ext_osc_en | output | 1 | External oscillator enable |
| ext_osc_bypass | output | 1 | External oscillator bypass |
| css_active | output | 1 | Clock-security detector active |
| pll_en | output | 1 | PLL enable |
| int_osc_trim | output | 5 | Internal oscillator trim |
| cko_en | output | 1 | Clock-output enable |
| cko_src | output | 2 | Clock-output source select |

## Verification
A corrupted enable or trim register shows on its output pin and in the read word on the edge after the write or hardware event that set it. Two faults have a narrow window. A wrong priority between the low-power clear and a software set shows only when both arrive in the same cycle. A broken PLL protection shows only when a write of 0 meets the PLL source code on either source input. Errors in the synchroniser depth show as a flag that changes one edge early or late, so the bench samples the ready bits after exactly one and two edges. Lane-gating errors show as a change in a byte whose strobe was low, so the vector table writes every lane alone and in combination.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned TRIM_W    = 5;
  localparam int unsigned CAL_W     = 8;
  localparam int unsigned CKO_W     = 3;

  localparam int unsigned B_INT_EN  = 0;
  localparam int unsigned B_INT_RDY = 1;
  localparam int unsigned TRIM_LO   = 3;
  localparam int unsigned CAL_LO    = 8;
  localparam int unsigned B_EXT_EN  = 16;
  localparam int unsigned B_EXT_RDY = 17;
  localparam int unsigned B_EXT_BYP = 18;
  localparam int unsigned B_CSS_EN  = 19;
  localparam int unsigned B_PLL_EN  = 24;
  localparam int unsigned B_PLL_RDY = 25;

  localparam logic [TRIM_W-1:0] TRIM_RST = 5'b10000;
  localparam logic [1:0]        SRC_PLL  = 2'b10;

  typedef struct packed {
    logic              int_en;
    logic [TRIM_W-1:0] trim;
    logic              ext_en;
    logic              ext_byp;
    logic              css_en;
    logic              pll_en;
  } ctrl_state_t;

  function automatic logic [REG_W-1:0] pack_ctrl(
    input ctrl_state_t      s,
    input logic             int_rdy,
    input logic             ext_rdy,
    input logic             pll_rdy,
    input logic [CAL_W-1:0] cal
  );
    logic [REG_W-1:0] r;
    r = '0;
    r[B_INT_EN]                  = s.int_en;
    r[B_INT_RDY]                 = int_rdy;
    r[TRIM_LO +: TRIM_W]         = s.trim;
    r[CAL_LO +: CAL_W]           = cal;
    r[B_EXT_EN]                  = s.ext_en;
    r[B_EXT_RDY]                 = ext_rdy;
    r[B_EXT_BYP]                 = s.ext_byp;
    r[B_CSS_EN]                  = s.css_en;
    r[B_PLL_EN]                  = s.pll_en;
    r[B_PLL_RDY]                 = pll_rdy;
    return r;
  endfunction

  function automatic logic pll_en_next(
    input logic cur,
    input logic sw_we,
    input logic sw_val,
    input logic protect,
    input logic lp
  );
    if (lp)                return 1'b0;
    if (sw_we && sw_val)   return 1'b1;
    if (sw_we && !protect) return 1'b0;
    return cur;
  endfunction

  function automatic logic pll_is_guarded(input logic [1:0] cur, input logic [1:0] nxt);
    return (cur == SRC_PLL) || (nxt == SRC_PLL);
  endfunction

endpackage

// File: rtl/ccr_sync.sv
module ccr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ccr_ctrl_bits.sv
module ccr_ctrl_bits
  import clk_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_lane0,
  input  logic              we_lane2,
  input  logic              d_int_en,
  input  logic [TRIM_W-1:0] d_trim,
  input  logic              d_ext_en,
  input  logic              d_ext_byp,
  input  logic              d_css_en,
  output logic              int_en,
  output logic [TRIM_W-1:0] trim,
  output logic              ext_en,
  output logic              ext_byp,
  output logic              css_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en <= 1'b1;
      trim   <= TRIM_RST;
    end else if (we_lane0) begin
      int_en <= d_int_en;
      trim   <= d_trim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en  <= 1'b0;
      ext_byp <= 1'b0;
      css_en  <= 1'b0;
    end else if (we_lane2) begin
      ext_en  <= d_ext_en;
      ext_byp <= d_ext_byp;
      css_en  <= d_css_en;
    end
  end
endmodule

// File: rtl/ccr_pll_gate.sv
module ccr_pll_gate
  import clk_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_we,
  input  logic sw_val,
  input  logic protect,
  input  logic lp_enter,
  output logic pll_en,
  output logic pll_clr_lp,
  output logic pll_sw_clr_blocked
);
  logic nxt;

  assign nxt                = pll_en_next(pll_en, sw_we, sw_val, protect, lp_enter);
  assign pll_clr_lp         = lp_enter && (pll_en || (sw_we && sw_val));
  assign pll_sw_clr_blocked = sw_we && !sw_val && protect && pll_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pll_en <= 1'b0;
    else        pll_en <= nxt;
  end
endmodule

// File: rtl/ccr_cko_sel.sv
module ccr_cko_sel
  import clk_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CKO_W-1:0] wdata,
  output logic [CKO_W-1:0] sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sel <= '0;
    else if (we) sel <= wdata;
  end
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
  import clk_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [3:0]  wr_strb,
  input  logic [31:0] wr_data,
  input  logic        rd_addr,
  output logic [31:0] rd_data,
  input  logic        int_osc_rdy_raw,
  input  logic        ext_osc_rdy_raw,
  input  logic        pll_lock,
  input  logic [7:0]  int_osc_cal,
  input  logic        stop_enter,
  input  logic        standby_enter,
  input  logic [1:0]  sysclk_cur,
  input  logic [1:0]  sysclk_next,
  output logic        int_osc_en,
  output logic        ext_osc_en,
  output logic        ext_osc_bypass,
  output logic        css_active,
  output logic        pll_en,
  output logic [4:0]  int_osc_trim,
  output logic        cko_en,
  output logic [1:0]  cko_src
);
  logic             ctrl_we, cko_we;
  logic             int_rdy_q, ext_rdy_q, pll_rdy_q;
  logic             css_en;
  logic             pll_protect, lp_enter;
  logic             pll_clr_lp, pll_sw_clr_blocked;
  logic [CKO_W-1:0] cko_sel;
  ctrl_state_t      st;
  logic             wr_data_unused;

  assign ctrl_we     = wr_en && !wr_addr;
  assign cko_we      = wr_en &&  wr_addr;
  assign lp_enter    = stop_enter || standby_enter;
  assign pll_protect = pll_is_guarded(sysclk_cur, sysclk_next);

  assign wr_data_unused = ^{wr_data[31:25], wr_data[23:20], wr_data[B_EXT_RDY], wr_data[15:8]};

  ccr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_int_sync (
    .clk(clk), .rst_n(rst_n), .d(int_osc_rdy_raw), .q(int_rdy_q));
  ccr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_osc_rdy_raw), .q(ext_rdy_q));
  ccr_sync #(.STAGES(1), .RST_VAL(1'b0)) u_pll_rdy (
    .clk(clk), .rst_n(rst_n), .d(pll_lock), .q(pll_rdy_q));

  ccr_ctrl_bits u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_lane0  (ctrl_we && wr_strb[0]),
    .we_lane2  (ctrl_we && wr_strb[2]),
    .d_int_en  (wr_data[B_INT_EN]),
    .d_trim    (wr_data[TRIM_LO +: TRIM_W]),
    .d_ext_en  (wr_data[B_EXT_EN]),
    .d_ext_byp (wr_data[B_EXT_BYP]),
    .d_css_en  (wr_data[B_CSS_EN]),
    .int_en    (int_osc_en),
    .trim      (int_osc_trim),
    .ext_en    (ext_osc_en),
    .ext_byp   (ext_osc_bypass),
    .css_en    (css_en)
  );

  ccr_pll_gate u_pll (
    .clk                (clk),
    .rst_n              (rst_n),
    .sw_we              (ctrl_we && wr_strb[3]),
    .sw_val             (wr_data[B_PLL_EN]),
    .protect            (pll_protect),
    .lp_enter           (lp_enter),
    .pll_en             (pll_en),
    .pll_clr_lp         (pll_clr_lp),
    .pll_sw_clr_blocked (pll_sw_clr_blocked)
  );

  ccr_cko_sel u_cko (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cko_we && wr_strb[0]),
    .wdata (wr_data[CKO_W-1:0]),
    .sel   (cko_sel)
  );

  assign cko_en     = cko_sel[2];
  assign cko_src    = cko_sel[1:0];
  assign css_active = css_en && ext_rdy_q;

  always_comb begin
    st.int_en  = int_osc_en;
    st.trim    = int_osc_trim;
    st.ext_en  = ext_osc_en;
    st.ext_byp = ext_osc_bypass;
    st.css_en  = css_en;
    st.pll_en  = pll_en;
  end

  always_comb begin
    if (rd_addr) rd_data = {{(REG_W-CKO_W){1'b0}}, cko_sel};
    else         rd_data = pack_ctrl(st, int_rdy_q, ext_rdy_q, pll_rdy_q, int_osc_cal);
  end
endmodule

// File: rtl/clk_ctrl_reg_chk.sv
module clk_ctrl_reg_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_addr,
  input logic        wr_lane0,
  input logic        rd_addr,
  input logic [31:0] rd_data,
  input logic        int_osc_rdy_raw,
  input logic        ext_osc_rdy_raw,
  input logic        pll_lock,
  input logic [7:0]  int_osc_cal,
  input logic        stop_enter,
  input logic        standby_enter,
  input logic [1:0]  sysclk_cur,
  input logic [1:0]  sysclk_next,
  input logic        int_osc_en,
  input logic [4:0]  int_osc_trim,
  input logic        css_active,
  input logic        pll_en,
  input logic        pll_sw_clr_blocked,
  input logic        int_rdy_q,
  input logic        ext_rdy_q,
  input logic        pll_rdy_q
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_lp_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_enter || standby_enter) |=> !pll_en);

  p_guard_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en && (sysclk_cur == 2'b10 || sysclk_next == 2'b10) && !stop_enter && !standby_enter)
    |=> pll_en);

  p_blocked_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_sw_clr_blocked && !stop_enter && !standby_enter) |=> pll_en);

  p_pll_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) |-> (pll_rdy_q == $past(pll_lock)));

  p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_addr |-> ((rd_data & 32'hFCF0_0004) == 32'h0));

  p_cko_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr |-> (rd_data[31:3] == 29'h0));

  p_cal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_addr |-> (rd_data[15:8] == int_osc_cal));

  p_lane0_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_addr && wr_lane0) |=> ($stable(int_osc_trim) && $stable(int_osc_en)));

  generate
    if (SYNC_STAGES == 2) begin : g_sync2
      p_ext_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (ext_rdy_q == $past(ext_osc_rdy_raw, 2)));

      p_int_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (int_rdy_q == $past(int_osc_rdy_raw, 2)));

      p_css_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (css_active && since_rst >= 2'd2) |-> $past(ext_osc_rdy_raw, 2));
    end
  endgenerate
endmodule

bind clk_ctrl_reg clk_ctrl_reg_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .wr_en              (wr_en),
  .wr_addr            (wr_addr),
  .wr_lane0           (wr_strb[0]),
  .rd_addr            (rd_addr),
  .rd_data            (rd_data),
  .int_osc_rdy_raw    (int_osc_rdy_raw),
  .ext_osc_rdy_raw    (ext_osc_rdy_raw),
  .pll_lock           (pll_lock),
  .int_osc_cal        (int_osc_cal),
  .stop_enter         (stop_enter),
  .standby_enter      (standby_enter),
  .sysclk_cur         (sysclk_cur),
  .sysclk_next        (sysclk_next),
  .int_osc_en         (int_osc_en),
  .int_osc_trim       (int_osc_trim),
  .css_active         (css_active),
  .pll_en             (pll_en),
  .pll_sw_clr_blocked (pll_sw_clr_blocked),
  .int_rdy_q          (int_rdy_q),
  .ext_rdy_q          (ext_rdy_q),
  .pll_rdy_q          (pll_rdy_q)
);

// File: tb/sim_clk_ctrl_reg.sv
`timescale 1ns/1ps
module sim_clk_ctrl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // each entry: {strobes, write data, expected control word}; calibration 0x5A, internal ready 1
  localparam logic [67:0] VEC [0:NVEC-1] = '{
    {4'hF, 32'hFFFF_FFFF, 32'h010D_5AFB},  // R2 R3 all lanes
    {4'h1, 32'h0000_0000, 32'h010D_5A02},  // R2 lane 0 only
    {4'h4, 32'h0000_0000, 32'h0100_5A02},  // R2 lane 2 only
    {4'h8, 32'h0000_0000, 32'h0000_5A02},  // R2 lane 3 only
    {4'h2, 32'hFFFF_FFFF, 32'h0000_5A02},  // R3 lane 1 read-only
    {4'h1, 32'h0000_00AF, 32'h0000_5AAB},  // R3 bits 1,2 ignored
    {4'h4, 32'h00FA_0000, 32'h0008_5AAB},  // R3 bits 17,20-23 ignored
    {4'h8, 32'hFF00_0000, 32'h0108_5AAB},  // R3 bits 25-31 ignored
    {4'h0, 32'hFFFF_FFFF, 32'h0108_5AAB},  // R2 no strobe
    {4'hC, 32'h0005_0000, 32'h0005_5AAB}   // R2 two lanes
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [3:0]  wr_strb = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        int_raw = 1'b1, ext_raw = 1'b0, pll_lock = 1'b0;
  logic [7:0]  cal = 8'h00;
  logic        stop_enter = 1'b0, standby_enter = 1'b0;
  logic [1:0]  sys_cur = 2'b00, sys_next = 2'b00;
  logic        int_osc_en, ext_osc_en, ext_osc_bypass, css_active, pll_en, cko_en;
  logic [4:0]  int_osc_trim;
  logic [1:0]  cko_src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ctrl_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .int_osc_rdy_raw(int_raw), .ext_osc_rdy_raw(ext_raw), .pll_lock(pll_lock),
    .int_osc_cal(cal), .stop_enter(stop_enter), .standby_enter(standby_enter),
    .sysclk_cur(sys_cur), .sysclk_next(sys_next), .int_osc_en(int_osc_en),
    .ext_osc_en(ext_osc_en), .ext_osc_bypass(ext_osc_bypass), .css_active(css_active),
    .pll_en(pll_en), .int_osc_trim(int_osc_trim), .cko_en(cko_en), .cko_src(cko_src));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_strb = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = 4'h0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); check("R1 control word", v, 32'h0000_0083);
    check("R1 enables", {26'h0, int_osc_en, ext_osc_en, ext_osc_bypass, css_active, pll_en, cko_en},
          32'h0000_0020);
    check("R1 trim", {27'h0, int_osc_trim}, 32'h10);
    rd(1'b1, v); check("R1 select reg", v, 32'h0);

    // R9 calibration live, R11 read without clock
    cal = 8'h5A;
    rd(1'b0, v); check("R9 R11 calibration", v, 32'h0000_5A83);

    // table walk, R2 R3
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b0, VEC[i][67:64], VEC[i][63:32]);
      rd(1'b0, v);
      check($sformatf("R2/R3 vector %0d", i), v, VEC[i][31:0]);
    end
    check("R2 outputs", {24'h0, int_osc_trim, int_osc_en, ext_osc_en, ext_osc_bypass},
          {24'h0, 5'h15, 3'b111});
    rd(1'b1, v); check("R10 select untouched by control writes", v, 32'h0);

    // R5 synchronisation depth
    @(negedge clk); ext_raw = 1'b1; int_raw = 1'b0;
    @(negedge clk); rd(1'b0, v);
    check("R5 ext after one edge", {31'h0, v[17]}, 32'h0);
    check("R5 int after one edge", {31'h0, v[1]}, 32'h1);
    @(negedge clk); rd(1'b0, v);
    check("R5 ext after two edges", {31'h0, v[17]}, 32'h1);
    check("R5 int after two edges", {31'h0, v[1]}, 32'h0);
    int_raw = 1'b1;
    repeat (3) @(negedge clk);

    // R8 security detector
    check("R8 off while enable clear", {31'h0, css_active}, 32'h0);
    wr(1'b0, 4'h4, 32'h0008_0000);
    check("R8 on with enable and ready", {31'h0, css_active}, 32'h1);
    ext_raw = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 off after ready drops", {31'h0, css_active}, 32'h0);

    // R4 PLL ready one-cycle
    pll_lock = 1'b1;
    @(negedge clk); rd(1'b0, v);
    check("R4 ready set", {31'h0, v[25]}, 32'h1);
    pll_lock = 1'b0;
    @(negedge clk); rd(1'b0, v);
    check("R4 ready clear", {31'h0, v[25]}, 32'h0);

    // R7 protection
    wr(1'b0, 4'h8, 32'h0100_0000);
    sys_cur = 2'b10;
    wr(1'b0, 4'h8, 32'h0000_0000);
    check("R7 kept while current is PLL", {31'h0, pll_en}, 32'h1);
    sys_cur = 2'b00; sys_next = 2'b10;
    wr(1'b0, 4'h8, 32'h0000_0000);
    check("R7 kept while requested is PLL", {31'h0, pll_en}, 32'h1);
    sys_next = 2'b01; sys_cur = 2'b01;
    wr(1'b0, 4'h8, 32'h0000_0000);
    check("R7 cleared when unguarded", {31'h0, pll_en}, 32'h0);
    sys_cur = 2'b00; sys_next = 2'b00;

    // R6 low-power clear priority
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_strb = 4'h8; wr_data = 32'h0100_0000; stop_enter = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = 4'h0; stop_enter = 1'b0;
    check("R6 stop beats set", {31'h0, pll_en}, 32'h0);
    wr(1'b0, 4'h8, 32'h0100_0000);
    sys_cur = 2'b10;
    @(negedge clk); standby_enter = 1'b1;
    @(negedge clk); standby_enter = 1'b0;
    check("R6 standby beats guard", {31'h0, pll_en}, 32'h0);
    sys_cur = 2'b00;

    // R10 output select
    wr(1'b1, 4'h1, 32'h0000_0005);
    check("R10 enable and source", {29'h0, cko_en, cko_src}, 32'h5);
    rd(1'b1, v); check("R10 readback", v, 32'h5);
    wr(1'b1, 4'hE, 32'h0000_0000);
    rd(1'b1, v); check("R10 lane 0 gate", v, 32'h5);
    wr(1'b1, 4'h1, 32'hFFFF_FFFF);
    rd(1'b1, v); check("R10 upper bits zero", v, 32'h7);
    wr(1'b1, 4'h1, 32'h0000_0003);
    check("R10 output disabled", {31'h0, cko_en}, 32'h0);
    rd(1'b0, v); check("R10 control word untouched", v, 32'h0008_5AAB);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule